// File: doc/BRIEF.md
# Flash Write-Status Output Generator

This block sits on the device side of a flash memory and decides what the data bus shows while an internal program or erase job runs. It takes commands (program, sector erase, erase suspend, erase resume, reset), tracks the job in an internal mode register, and on every read returns either array data or a status byte. The status byte carries a polarity bit, two read-toggled bits, a timeout bit and an erase-window bit. A separate active-low ready/busy line goes low while a job is in progress.

The real program and erase algorithms are replaced by down-counters whose lengths are parameters in clock cycles. A program job lasts `PROG_CYC` cycles, or `PPROG_CYC` cycles if its sector is protected. An erase opens an acceptance window of `ACC_CYC` cycles and then runs for `ERASE_CYC` cycles. If every selected sector is protected, the erase runs for `PERASE_CYC` cycles instead. The host tells a running job from a finished one by sampling the polarity bit or by comparing two successive reads of the toggle bits.

Top module: `flash_status_gen`

## Requirements
- R1: While a program runs, in normal mode or with an erase suspended, dq_out[7] is the inverse of the bit latched from prog_bit with the program command.
- R2: During an erase, including its acceptance window, dq_out[7] reads 0. In erase-suspend-read mode, a read of a selected sector returns dq_out[7] = 1. After the erase completes the block is back in read mode.
- R3: dq_out[6] inverts on each rising edge of rd_strobe, at any address, while a program, an erase or a suspended-erase program is running. It holds its value in erase-suspend-read mode and when no strobe edge occurs.
- R4: dq_out[2] inverts on a rising edge of rd_strobe only when rd_sector is in the erase-selected set and the mode is active erase or erase-suspend-read. Reads of other sectors, and reads during a program, leave it unchanged.
- R5: dq_out[3] reads 0 for ACC_CYC cycles after the latest sector-erase command and 1 afterwards. A sector-erase command during the window adds its sector to the selected set and restarts the window.
- R6: ry_by_n is 0 during program, erase and suspended-erase program, and 1 in read and erase-suspend-read modes. An unprotected program keeps it low for exactly PROG_CYC cycles. An erase keeps it low for ACC_CYC + ERASE_CYC cycles after its last accepted sector-erase command.
- R7: A program to a sector whose prot_mask bit is 1 is busy for PPROG_CYC cycles and then returns to read mode. An erase whose selected sectors are all protected is busy for ACC_CYC + PERASE_CYC cycles.
- R8: In read mode, and in erase-suspend-read mode for a sector outside the selected set, dq_out equals array_dq.
- R9: A timeout_hit pulse during a busy job sets dq_out[5] to 1, freezes the job and keeps ry_by_n at 0 until a reset command.
- R10: A reset command after a timeout clears dq_out[5]. It returns to read mode, or to erase-suspend-read if the failed job was a suspended-erase program. A reset command with no timeout pending has no effect.
- R11: Erase suspend is accepted only after the acceptance window. A sector-erase command after the window is ignored. Resume continues the erase with the cycles that were left.
- R12: Status bytes carry status only at bits 7, 6, 5, 3 and 2, and bits 4, 1 and 0 read 0. The cmd_code values are 1 program, 2 sector erase, 3 erase suspend, 4 erase resume and 5 reset. A command counts only when cmd_valid is high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 3 | Command code (R12) |
| cmd_sector | input | SW | Target sector of a program or sector-erase command |
| prog_bit | input | 1 | Bit being programmed into data bit 7 |
| prot_mask | input | NSEC | Per-sector protection flags |
| timeout_hit | input | 1 | Internal pulse-count limit exceeded |
| rd_strobe | input | 1 | Read strobe, toggle bits advance on its rising edge |
| rd_sector | input | SW | Sector of the current read address |
| array_dq | input | DW | Array data for non-status reads |
| dq_out | output | DW | Data bus value: array data or status byte |
| ry_by_n | output | 1 | Ready (1) or busy (0) |

## Verification
The bench measures busy durations. A design whose window or erase counter is off by one, or that fails to restart the window on an added sector, returns a different count. It reads a selected sector twice and an unselected sector twice, in both active erase and erase suspend. A design that toggles the sector bit for every address, or keeps the global toggle running while suspended, shows up in those pairs. It suspends during the acceptance window, sends a sector-erase after the window and resumes after a suspend. A design that accepts the early suspend, widens the sector set late or restarts the erase counter on resume gives the wrong ready/busy timing or returns status where array data belongs. Timeouts in a normal program and in a suspended-erase program, each followed by reset, catch a block that returns to the wrong mode.

// File: rtl/flash_status_pkg.sv
// Shared types for the flash write-status generator.
// Assumes: command codes are fixed by the host protocol (R12).
package flash_status_pkg;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_PROG   = 3'd1,
        CMD_SERASE = 3'd2,
        CMD_SUSP   = 3'd3,
        CMD_RESUME = 3'd4,
        CMD_RESET  = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        ST_READ      = 3'd0,
        ST_PROG      = 3'd1,
        ST_ERASE     = 3'd2,
        ST_SUSP_RD   = 3'd3,
        ST_SUSP_PROG = 3'd4
    } mode_e;

    localparam int POS_POLL  = 7;
    localparam int POS_TOG   = 6;
    localparam int POS_FAIL  = 5;
    localparam int POS_WIN   = 3;
    localparam int POS_STOG  = 2;

endpackage

// File: rtl/fsg_seq.sv
// Job sequencer: holds the operation mode, the erase-selected sector set,
// the acceptance-window flag, the failure flag and the busy counters.
// Assumes: every cycle parameter is at least 1; one command per cycle.
module fsg_seq
    import flash_status_pkg::*;
#(
    parameter int NSEC       = 8,
    parameter int PROG_CYC   = 8,
    parameter int PPROG_CYC  = 3,
    parameter int ACC_CYC    = 6,
    parameter int ERASE_CYC  = 20,
    parameter int PERASE_CYC = 10,
    localparam int SW        = $clog2(NSEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_code,
    input  logic [SW-1:0]   cmd_sector,
    input  logic            prog_bit,
    input  logic [NSEC-1:0] prot_mask,
    input  logic            timeout_hit,
    output mode_e           mode,
    output logic [NSEC-1:0] sel_mask,
    output logic            acc_done,
    output logic            fail,
    output logic            pbit_q
);

    localparam int PMAX = (PROG_CYC > PPROG_CYC) ? PROG_CYC : PPROG_CYC;
    localparam int EMX1 = (ERASE_CYC > PERASE_CYC) ? ERASE_CYC : PERASE_CYC;
    localparam int EMAX = (EMX1 > ACC_CYC) ? EMX1 : ACC_CYC;
    localparam int CMAX = (PMAX > EMAX) ? PMAX : EMAX;
    localparam int CW   = $clog2(CMAX + 1);

    logic [CW-1:0]   pcnt;
    logic [CW-1:0]   ecnt;
    logic [NSEC-1:0] sec_bit;
    cmd_e            cmd;
    logic            is_prog, is_erase, is_susp, is_resume, is_reset;

    // Decode the command strobe into one flag per command.
    always_comb begin
        cmd       = cmd_e'(cmd_code);
        sec_bit   = NSEC'(1) << cmd_sector;
        is_prog   = cmd_valid && (cmd == CMD_PROG);
        is_erase  = cmd_valid && (cmd == CMD_SERASE);
        is_susp   = cmd_valid && (cmd == CMD_SUSP);
        is_resume = cmd_valid && (cmd == CMD_RESUME);
        is_reset  = cmd_valid && (cmd == CMD_RESET);
    end

    // Advance the mode, counters and flags one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= ST_READ;
            sel_mask <= '0;
            acc_done <= 1'b0;
            fail     <= 1'b0;
            pbit_q   <= 1'b0;
            pcnt     <= '0;
            ecnt     <= '0;
        end else begin
            unique case (mode)
                ST_READ: begin
                    if (is_prog) begin
                        mode   <= ST_PROG;
                        pbit_q <= prog_bit;
                        pcnt   <= prot_mask[cmd_sector] ? CW'(PPROG_CYC - 1) : CW'(PROG_CYC - 1);
                    end else if (is_erase) begin
                        mode     <= ST_ERASE;
                        sel_mask <= sec_bit;
                        acc_done <= 1'b0;
                        ecnt     <= CW'(ACC_CYC - 1);
                    end
                end
                ST_PROG, ST_SUSP_PROG: begin
                    if (fail) begin
                        if (is_reset) begin
                            fail <= 1'b0;
                            mode <= (mode == ST_SUSP_PROG) ? ST_SUSP_RD : ST_READ;
                        end
                    end else if (timeout_hit) begin
                        fail <= 1'b1;
                    end else if (pcnt == '0) begin
                        mode <= (mode == ST_SUSP_PROG) ? ST_SUSP_RD : ST_READ;
                    end else begin
                        pcnt <= pcnt - CW'(1);
                    end
                end
                ST_ERASE: begin
                    if (fail) begin
                        if (is_reset) begin
                            fail     <= 1'b0;
                            mode     <= ST_READ;
                            sel_mask <= '0;
                            acc_done <= 1'b0;
                        end
                    end else if (timeout_hit) begin
                        fail <= 1'b1;
                    end else if (!acc_done) begin
                        if (is_erase) begin
                            sel_mask <= sel_mask | sec_bit;
                            ecnt     <= CW'(ACC_CYC - 1);
                        end else if (ecnt == '0) begin
                            acc_done <= 1'b1;
                            ecnt     <= ((sel_mask & ~prot_mask) == '0) ?
                                        CW'(PERASE_CYC - 1) : CW'(ERASE_CYC - 1);
                        end else begin
                            ecnt <= ecnt - CW'(1);
                        end
                    end else begin
                        if (is_susp) begin
                            mode <= ST_SUSP_RD;
                        end else if (ecnt == '0) begin
                            mode     <= ST_READ;
                            sel_mask <= '0;
                            acc_done <= 1'b0;
                        end else begin
                            ecnt <= ecnt - CW'(1);
                        end
                    end
                end
                ST_SUSP_RD: begin
                    if (is_prog) begin
                        mode   <= ST_SUSP_PROG;
                        pbit_q <= prog_bit;
                        pcnt   <= prot_mask[cmd_sector] ? CW'(PPROG_CYC - 1) : CW'(PROG_CYC - 1);
                    end else if (is_resume) begin
                        mode <= ST_ERASE;
                    end
                end
                default: mode <= ST_READ;
            endcase
        end
    end

    // R9
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !is_reset) |=> ($stable(pcnt) && $stable(ecnt) && fail));

    // R6
    fail_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (mode != ST_READ && mode != ST_SUSP_RD));

    // R11
    sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_ERASE && acc_done) |=> (sel_mask == $past(sel_mask) || mode == ST_READ));

endmodule

// File: rtl/fsg_toggle.sv
// Toggle-bit generator: detects rising edges of the read strobe and flips
// the global toggle bit (any address, job running) and the sector toggle
// bit (selected sector, erase active or suspended).
// Assumes: rd_strobe is synchronous to clk.
module fsg_toggle
    import flash_status_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_strobe,
    input  mode_e mode,
    input  logic  rd_in_sel,
    output logic  tog_all,
    output logic  tog_sec
);

    logic rd_q;
    logic rise;
    logic job_run;
    logic sec_mode;

    // Qualify a strobe edge and the modes in which each bit may move.
    always_comb begin
        rise     = rd_strobe && !rd_q;
        job_run  = (mode == ST_PROG) || (mode == ST_ERASE) || (mode == ST_SUSP_PROG);
        sec_mode = (mode == ST_ERASE) || (mode == ST_SUSP_RD);
    end

    // Register the strobe and flip the toggle bits on qualified edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            tog_all <= 1'b0;
            tog_sec <= 1'b0;
        end else begin
            rd_q <= rd_strobe;
            if (rise && job_run) begin
                tog_all <= !tog_all;
            end
            if (rise && sec_mode && rd_in_sel) begin
                tog_sec <= !tog_sec;
            end
        end
    end

    // R3
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> ($stable(tog_all) && $stable(tog_sec)));

    // R3
    susp_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_SUSP_RD) |=> $stable(tog_all));

endmodule

// File: rtl/fsg_mux.sv
// Output selector: builds the status byte from mode and flags and picks
// between it and array data; drives the ready/busy line.
// Assumes: DW is at least 8 so the status bit positions exist.
module fsg_mux
    import flash_status_pkg::*;
#(
    parameter int DW = 8
) (
    input  mode_e         mode,
    input  logic          acc_done,
    input  logic          fail,
    input  logic          pbit_q,
    input  logic          tog_all,
    input  logic          tog_sec,
    input  logic          rd_in_sel,
    input  logic [DW-1:0] array_dq,
    output logic [DW-1:0] dq_out,
    output logic          ry_by_n
);

    logic [DW-1:0] stat;
    logic          use_array;

    // Compose the status byte for the current mode.
    always_comb begin
        stat = '0;
        unique case (mode)
            ST_PROG, ST_SUSP_PROG: begin
                stat[POS_POLL] = !pbit_q;
                stat[POS_TOG]  = tog_all;
                stat[POS_FAIL] = fail;
                stat[POS_STOG] = tog_sec;
            end
            ST_ERASE: begin
                stat[POS_POLL] = 1'b0;
                stat[POS_TOG]  = tog_all;
                stat[POS_FAIL] = fail;
                stat[POS_WIN]  = acc_done;
                stat[POS_STOG] = tog_sec;
            end
            ST_SUSP_RD: begin
                stat[POS_POLL] = 1'b1;
                stat[POS_TOG]  = tog_all;
                stat[POS_WIN]  = 1'b1;
                stat[POS_STOG] = tog_sec;
            end
            default: stat = '0;
        endcase
    end

    // Choose array data or status and derive ready/busy.
    always_comb begin
        use_array = (mode == ST_READ) || ((mode == ST_SUSP_RD) && !rd_in_sel);
        dq_out    = use_array ? array_dq : stat;
        ry_by_n   = (mode == ST_READ) || (mode == ST_SUSP_RD);
    end

endmodule

// File: rtl/flash_status_gen.sv
// Top of the flash write-status generator: sequencer, toggle logic and
// output selector.
// Assumes: NSEC is a power of two; all inputs synchronous to clk.
module flash_status_gen
    import flash_status_pkg::*;
#(
    parameter int NSEC       = 8,
    parameter int DW         = 8,
    parameter int PROG_CYC   = 8,
    parameter int PPROG_CYC  = 3,
    parameter int ACC_CYC    = 6,
    parameter int ERASE_CYC  = 20,
    parameter int PERASE_CYC = 10,
    localparam int SW        = $clog2(NSEC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_code,
    input  logic [SW-1:0]   cmd_sector,
    input  logic            prog_bit,
    input  logic [NSEC-1:0] prot_mask,
    input  logic            timeout_hit,
    input  logic            rd_strobe,
    input  logic [SW-1:0]   rd_sector,
    input  logic [DW-1:0]   array_dq,
    output logic [DW-1:0]   dq_out,
    output logic            ry_by_n
);

    mode_e           mode;
    logic [NSEC-1:0] sel_mask;
    logic            acc_done;
    logic            fail;
    logic            pbit_q;
    logic            tog_all;
    logic            tog_sec;
    logic            rd_in_sel;

    // Membership of the read sector in the erase-selected set.
    assign rd_in_sel = sel_mask[rd_sector];

    fsg_seq #(
        .NSEC(NSEC), .PROG_CYC(PROG_CYC), .PPROG_CYC(PPROG_CYC),
        .ACC_CYC(ACC_CYC), .ERASE_CYC(ERASE_CYC), .PERASE_CYC(PERASE_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_sector(cmd_sector), .prog_bit(prog_bit), .prot_mask(prot_mask),
        .timeout_hit(timeout_hit), .mode(mode), .sel_mask(sel_mask),
        .acc_done(acc_done), .fail(fail), .pbit_q(pbit_q)
    );

    fsg_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .mode(mode),
        .rd_in_sel(rd_in_sel), .tog_all(tog_all), .tog_sec(tog_sec)
    );

    fsg_mux #(.DW(DW)) u_mux (
        .mode(mode), .acc_done(acc_done), .fail(fail), .pbit_q(pbit_q),
        .tog_all(tog_all), .tog_sec(tog_sec), .rd_in_sel(rd_in_sel),
        .array_dq(array_dq), .dq_out(dq_out), .ry_by_n(ry_by_n)
    );

    // R9
    fail_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (!ry_by_n && dq_out[POS_FAIL]));

    // R12
    spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ry_by_n |-> (dq_out[4] == 1'b0 && dq_out[1:0] == 2'b00));

endmodule

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;

    localparam int CLK_PERIOD = 10;
    localparam int NSEC = 8;
    localparam int DW = 8;
    localparam int PROG_CYC = 8;
    localparam int PPROG_CYC = 3;
    localparam int ACC_CYC = 6;
    localparam int ERASE_CYC = 20;
    localparam int PERASE_CYC = 10;

    localparam logic [2:0] C_PROG = 3'd1;
    localparam logic [2:0] C_ERASE = 3'd2;
    localparam logic [2:0] C_SUSP = 3'd3;
    localparam logic [2:0] C_RES = 3'd4;
    localparam logic [2:0] C_RST = 3'd5;

    logic clk = 1'b0;
    logic rst_n, cmd_valid, prog_bit, timeout_hit, rd_strobe, ry_by_n;
    logic [2:0] cmd_code, cmd_sector, rd_sector;
    logic [NSEC-1:0] prot_mask;
    logic [DW-1:0] array_dq, dq_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_gen #(
        .NSEC(NSEC), .DW(DW), .PROG_CYC(PROG_CYC), .PPROG_CYC(PPROG_CYC),
        .ACC_CYC(ACC_CYC), .ERASE_CYC(ERASE_CYC), .PERASE_CYC(PERASE_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_sector(cmd_sector), .prog_bit(prog_bit), .prot_mask(prot_mask),
        .timeout_hit(timeout_hit), .rd_strobe(rd_strobe), .rd_sector(rd_sector),
        .array_dq(array_dq), .dq_out(dq_out), .ry_by_n(ry_by_n)
    );

    function automatic int exp_prog_busy(input bit prot);
        return prot ? PPROG_CYC : PROG_CYC;
    endfunction

    function automatic int exp_erase_busy(input bit all_prot);
        return ACC_CYC + (all_prot ? PERASE_CYC : ERASE_CYC);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic do_cmd(input logic [2:0] c, input int s, input logic b);
        cmd_valid = 1'b1; cmd_code = c; cmd_sector = s[2:0]; prog_bit = b;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 3'd0;
    endtask

    task automatic do_rd(input int s, output logic [DW-1:0] v);
        rd_sector = s[2:0]; rd_strobe = 1'b1;
        @(negedge clk);
        v = dq_out;
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (!ry_by_n && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_ready();
        int g = 0;
        while (!ry_by_n && g < 2000) begin g++; @(negedge clk); end
    endtask

    task automatic wait_window();
        int g = 0;
        while (!dq_out[3] && g < 2000) begin g++; @(negedge clk); end
    endtask

    task automatic pulse_timeout();
        timeout_hit = 1'b1;
        @(negedge clk);
        timeout_hit = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v1, v2;
        int n;
        void'($urandom(32'd1234));
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 3'd0; cmd_sector = 3'd0;
        prog_bit = 1'b0; prot_mask = '0; timeout_hit = 1'b0; rd_strobe = 1'b0;
        rd_sector = 3'd0; array_dq = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: ready, array data passes (R6, R8)
        array_dq = 8'hA5; #1;
        chk(ry_by_n == 1'b1, "R6 reset ready", ry_by_n, 1);
        chk(dq_out == 8'hA5, "R8 reset read", dq_out, 8'hA5);
        @(negedge clk);

        // Program busy length (R6)
        do_cmd(C_PROG, 2, 1'b1);
        count_busy(n);
        chk(n == exp_prog_busy(0), "R6 program busy", n, exp_prog_busy(0));

        // Program status bits (R1, R3, R4, R12)
        do_cmd(C_PROG, 3, 1'b0);
        do_rd(5, v1);
        do_rd(1, v2);
        chk(v1[7] == 1'b1, "R1 inverted polling bit", v1[7], 1);
        chk(v1[6] != v2[6], "R3 toggle during program", v2[6], !v1[6]);
        chk(v1[2] == v2[2], "R4 no sector toggle in program", v2[2], v1[2]);
        chk((v1 & 8'h13) == 8'h00, "R12 spare bits zero", v1 & 8'h13, 0);
        chk(v1[5] == 1'b0, "R9 no timeout bit", v1[5], 0);
        wait_ready();
        array_dq = 8'h3C;
        do_rd(4, v1);
        chk(v1 == 8'h3C, "R8 read after program", v1, 8'h3C);

        // Random programs and reads (R1, R8)
        for (int i = 0; i < 16; i++) begin
            logic b;
            int s;
            logic [DW-1:0] a;
            b = 1'($urandom % 2);
            s = int'($urandom % NSEC);
            do_cmd(C_PROG, s, b);
            do_rd(int'($urandom % NSEC), v1);
            chk(v1[7] == !b, "R1 random program polling", v1[7], !b);
            wait_ready();
            a = 8'($urandom);
            array_dq = a;
            do_rd(int'($urandom % NSEC), v1);
            chk(v1 == a, "R8 random array read", v1, a);
        end

        // Erase with window restart (R5, R2)
        do_cmd(C_ERASE, 1, 1'b0);
        @(negedge clk); @(negedge clk);
        do_cmd(C_ERASE, 2, 1'b0);
        chk(dq_out[7] == 1'b0, "R2 erase polling zero", dq_out[7], 0);
        n = 0;
        while (!dq_out[3] && n < 100) begin n++; @(negedge clk); end
        chk(n == ACC_CYC, "R5 window restarted", n, ACC_CYC);
        // Late sector-erase ignored, then suspend (R11)
        do_cmd(C_ERASE, 6, 1'b0);
        do_cmd(C_SUSP, 0, 1'b0);
        chk(ry_by_n == 1'b1, "R6 ready in suspend", ry_by_n, 1);
        do_rd(1, v1);
        do_rd(1, v2);
        chk(v1[7] == 1'b1, "R2 suspend polling one", v1[7], 1);
        chk(v1[2] != v2[2], "R4 sector toggle in suspend", v2[2], !v1[2]);
        chk(v1[6] == v2[6], "R3 steady toggle in suspend", v2[6], v1[6]);
        array_dq = 8'h5A;
        do_rd(6, v1);
        chk(v1 == 8'h5A, "R11 late sector not selected", v1, 8'h5A);
        do_rd(3, v1);
        chk(v1 == 8'h5A, "R8 unselected sector in suspend", v1, 8'h5A);
        // Program during suspend (R1, R3, R6)
        do_cmd(C_PROG, 3, 1'b1);
        chk(ry_by_n == 1'b0, "R6 busy in suspend program", ry_by_n, 0);
        do_rd(0, v1);
        do_rd(0, v2);
        chk(v1[7] == 1'b0, "R1 suspend program polling", v1[7], 0);
        chk(v1[6] != v2[6], "R3 toggle in suspend program", v2[6], !v1[6]);
        wait_ready();
        do_rd(2, v1);
        chk(v1[7] == 1'b1, "R2 back in suspend read", v1[7], 1);
        // Resume keeps remaining cycles (R11)
        do_cmd(C_RES, 0, 1'b0);
        chk(dq_out[7] == 1'b0, "R2 resumed erase polling", dq_out[7], 0);
        count_busy(n);
        chk(n == ERASE_CYC - 1, "R11 resume remaining", n, ERASE_CYC - 1);

        // Sector toggle only on selected sectors in active erase (R4, R3)
        do_cmd(C_ERASE, 0, 1'b0);
        wait_window();
        do_rd(0, v1);
        do_rd(0, v2);
        chk(v1[2] != v2[2], "R4 selected sector toggles", v2[2], !v1[2]);
        do_rd(7, v1);
        do_rd(7, v2);
        chk(v1[2] == v2[2], "R4 unselected sector steady", v2[2], v1[2]);
        chk(v1[6] != v2[6], "R3 toggle any address in erase", v2[6], !v1[6]);
        wait_ready();

        // Suspend inside the window is ignored (R11)
        do_cmd(C_ERASE, 5, 1'b0);
        do_cmd(C_SUSP, 0, 1'b0);
        chk(ry_by_n == 1'b0, "R11 early suspend ignored", ry_by_n, 1'b0);
        chk(dq_out[3] == 1'b0, "R5 still in window", dq_out[3], 0);
        count_busy(n);
        chk(n == ACC_CYC - 1 + ERASE_CYC, "R11 early suspend timing", n, ACC_CYC - 1 + ERASE_CYC);

        // Protected sectors (R7)
        prot_mask = 8'h10;
        do_cmd(C_PROG, 4, 1'b1);
        count_busy(n);
        chk(n == exp_prog_busy(1), "R7 protected program", n, exp_prog_busy(1));
        do_cmd(C_ERASE, 4, 1'b0);
        count_busy(n);
        chk(n == exp_erase_busy(1), "R7 all protected erase", n, exp_erase_busy(1));
        do_cmd(C_ERASE, 4, 1'b0);
        do_cmd(C_ERASE, 5, 1'b0);
        count_busy(n);
        chk(n == exp_erase_busy(0), "R7 partly protected erase", n, exp_erase_busy(0));
        prot_mask = '0;

        // Timeout in program then reset (R9, R10)
        array_dq = 8'h00;
        do_cmd(C_PROG, 0, 1'b1);
        pulse_timeout();
        chk(dq_out[5] == 1'b1, "R9 timeout bit set", dq_out[5], 1);
        chk(ry_by_n == 1'b0, "R9 busy on timeout", ry_by_n, 0);
        repeat (40) @(negedge clk);
        chk(ry_by_n == 1'b0 && dq_out[5] == 1'b1, "R9 held until reset", {ry_by_n, dq_out[5]}, 1);
        do_cmd(C_RST, 0, 1'b0);
        chk(ry_by_n == 1'b1, "R10 reset to read", ry_by_n, 1);
        chk(dq_out == 8'h00, "R10 timeout bit cleared", dq_out, 0);

        // Reset without timeout has no effect (R10)
        do_cmd(C_PROG, 1, 1'b0);
        do_cmd(C_RST, 0, 1'b0);
        count_busy(n);
        chk(n == PROG_CYC - 1, "R10 reset ignored", n, PROG_CYC - 1);

        // Timeout in suspended-erase program returns to suspend read (R10)
        do_cmd(C_ERASE, 2, 1'b0);
        wait_window();
        do_cmd(C_SUSP, 0, 1'b0);
        do_cmd(C_PROG, 3, 1'b0);
        pulse_timeout();
        chk(dq_out[5] == 1'b1, "R9 timeout in suspend program", dq_out[5], 1);
        do_cmd(C_RST, 0, 1'b0);
        chk(ry_by_n == 1'b1, "R10 ready after reset", ry_by_n, 1);
        do_rd(2, v1);
        chk(v1[7] == 1'b1 && v1[5] == 1'b0, "R10 back to suspend read", v1, 8'h80);
        do_cmd(C_RES, 0, 1'b0);
        wait_ready();

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule